// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps a free-running 48-bit time count that advances on a 32.768 kHz tick enable. Because the tick rate is 2^15 per second, bit 15 of the count is the one-second bit. Software reads and loads the count as three 16-bit halfwords. It also loads a 48-bit alarm value, split the same way, into three further halfwords. When the count first becomes equal to the alarm value, the block latches an alarm status flag. Software clears that flag by writing a one to it. A level interrupt follows the flag when the interrupt enable bit is set.

Access is through a simple halfword register port. A read is combinational from the address. A write takes effect at the next clock edge. Reads are not latched, so software reads the counter twice to get a consistent value. A one-shot match state machine makes sure the flag is raised once per equality episode, not on every cycle while the two values stay equal. It has two states:

- ST_ARMED: the values are unequal. The transition ARMED→HELD is taken when they become equal, and it raises the flag.
- ST_HELD: equality has been seen. The transition HELD→ARMED is taken when the values differ again.

Reset enters ST_HELD, so the all-zero equality present at reset does not fire.

Top module: `etime_alarm`

## Requirements
- R1: The counter advances by exactly one on each clock edge where `tick` is high and no counter halfword is written. It holds its value otherwise.
- R2: The counter halfwords are read at byte offset 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). Whole seconds equal high<<17 | middle<<1 | low>>15.
- R3: A write to a counter halfword replaces only those 16 bits, visible from the next cycle. A tick in the same cycle as a counter write is dropped.
- R4: The alarm value is written and read back at 0x08 (bits 15:0), 0x0A (bits 31:16) and 0x0C (bits 47:32).
- R5: The status register sits at 0x1E, with bit 0 as the alarm flag and bits 15:1 always reading zero. The flag is set at the clock edge that ends the first cycle in which count equals alarm value.
- R6: The flag is raised at most once per equality episode. Clearing it while the values remain equal does not set it again. The equality present at reset does not set it.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R8: `irq` is high exactly when the flag is set and bit 0 of the enable register at 0x1C is 1.
- R9: The counter wraps from 2^48−1 to zero on a tick.
- R10: After reset, the counter, alarm value, flag, enable bit and `irq` are all zero.
- R11: Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32.768 kHz time-base enable, one clock wide |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the halfword |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The bench targets these failure modes:

- **Same-edge set and clear on the flag.** A design that let the clear win would lose an alarm.
- **Equality held across many cycles, and the equality at reset.** A level-compare design would refire after each clear, or fire straight out of reset.
- **A counter write in a tick cycle.** A design that merged the tick would read back the written value plus one.
- **A halfword load.** A design that disturbed the neighbouring bits would break the seconds split.
- **Wrap from all ones to zero.** A design missing it would stop at all ones.
- **Writes to unmapped offsets and to the flag's upper bits.** A loose decode would corrupt the count or the alarm value.

// File: rtl/etime_pkg.sv
package etime_pkg;
    localparam int HW_W    = 16;
    localparam int ADDR_W  = 5;
    localparam int IDX_W   = ADDR_W - 1;
    // halfword index = byte offset >> 1
    localparam logic [IDX_W-1:0] IDX_CNT0 = 4'd0;   // 0x00
    localparam logic [IDX_W-1:0] IDX_CMP0 = 4'd4;   // 0x08
    localparam logic [IDX_W-1:0] IDX_IEN  = 4'd14;  // 0x1C
    localparam logic [IDX_W-1:0] IDX_STAT = 4'd15;  // 0x1E

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } match_st_t;
endpackage

// File: rtl/etime_counter.sv
module etime_counter #(
    parameter int CNT_W = 48,
    parameter int HW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [CNT_W/HW-1:0]  wr_hw,
    input  logic [HW-1:0]        wdata,
    output logic [CNT_W-1:0]     cnt
);
    localparam int NHW = CNT_W / HW;

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (|wr_hw) begin
            for (int i = 0; i < NHW; i++) begin
                if (wr_hw[i]) cnt_nxt[i*HW +: HW] = wdata;
            end
        end else if (tick) begin
            cnt_nxt = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(|wr_hw)) |=> (cnt == $past(cnt) + CNT_W'(1)));
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(|wr_hw)) |=> $stable(cnt));
    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hw[0] && !wr_hw[1]) |=> (cnt[HW-1:0] == $past(wdata)
                                     && cnt[2*HW-1:HW] == $past(cnt[2*HW-1:HW])));
endmodule

// File: rtl/etime_cmp_regs.sv
module etime_cmp_regs #(
    parameter int CNT_W = 48,
    parameter int HW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W/HW-1:0]  wr_hw,
    input  logic [HW-1:0]        wdata,
    output logic [CNT_W-1:0]     cmp
);
    localparam int NHW = CNT_W / HW;

    for (genvar g = 0; g < NHW; g++) begin : g_hw
        always_ff @(posedge clk) begin
            if (!rst_n)        cmp[g*HW +: HW] <= '0;
            else if (wr_hw[g]) cmp[g*HW +: HW] <= wdata;
        end
    end

    // R4
    cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_hw) |=> $stable(cmp));
endmodule

// File: rtl/etime_irq_ctl.sv
module etime_irq_ctl
    import etime_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eq,
    input  logic clr,
    input  logic ien_wr,
    input  logic ien_wbit,
    output logic flag,
    output logic ien,
    output logic irq
);
    match_st_t st, st_nxt;
    logic      set_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HELD;
        else        st <= st_nxt;
    end

    // next state and outputs
    always_comb begin
        st_nxt  = st;
        set_req = 1'b0;
        unique case (st)
            ST_ARMED: if (eq) begin
                st_nxt  = ST_HELD;
                set_req = 1'b1;
            end
            ST_HELD:  if (!eq) st_nxt = ST_ARMED;
            default:  st_nxt = ST_HELD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            ien  <= 1'b0;
        end else begin
            if (set_req)  flag <= 1'b1;
            else if (clr) flag <= 1'b0;
            if (ien_wr)   ien  <= ien_wbit;
        end
    end

    assign irq = flag & ien;

    // R5
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(eq));
    // R6
    flag_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HELD) |=> !$rose(flag));
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(st == ST_ARMED && eq)) |=> !flag);
    // R7
    flag_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && eq) |=> flag);
endmodule

// File: rtl/etime_alarm.sv
module etime_alarm
    import etime_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HW_W-1:0]   bus_wdata,
    output logic [HW_W-1:0]   bus_rdata,
    output logic              irq
);
    localparam int NHW = CNT_W / HW_W;

    logic [IDX_W-1:0] idx;
    logic             wr_any;
    logic [NHW-1:0]   wr_cnt_hw, wr_cmp_hw;
    logic [CNT_W-1:0] cnt, cmp;
    logic             eq, flag, ien;

    assign idx    = bus_addr[ADDR_W-1:1];
    assign wr_any = bus_sel && bus_wr;

    for (genvar g = 0; g < NHW; g++) begin : g_dec
        assign wr_cnt_hw[g] = wr_any && (idx == IDX_CNT0 + IDX_W'(g));
        assign wr_cmp_hw[g] = wr_any && (idx == IDX_CMP0 + IDX_W'(g));
    end

    etime_counter #(.CNT_W(CNT_W), .HW(HW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_hw(wr_cnt_hw), .wdata(bus_wdata), .cnt(cnt)
    );

    etime_cmp_regs #(.CNT_W(CNT_W), .HW(HW_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_hw(wr_cmp_hw), .wdata(bus_wdata), .cmp(cmp)
    );

    assign eq = (cnt == cmp);

    etime_irq_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .eq(eq),
        .clr(wr_any && idx == IDX_STAT && bus_wdata[0]),
        .ien_wr(wr_any && idx == IDX_IEN), .ien_wbit(bus_wdata[0]),
        .flag(flag), .ien(ien), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NHW; i++) begin
            if (idx == IDX_CNT0 + IDX_W'(i)) bus_rdata = cnt[i*HW_W +: HW_W];
            if (idx == IDX_CMP0 + IDX_W'(i)) bus_rdata = cmp[i*HW_W +: HW_W];
        end
        if (idx == IDX_IEN)  bus_rdata = {{(HW_W-1){1'b0}}, ien};
        if (idx == IDX_STAT) bus_rdata = {{(HW_W-1){1'b0}}, flag};
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && idx == IDX_IEN && !bus_wdata[0]) |=> !irq);
endmodule

// File: tb/etime_alarm_test.sv
module etime_alarm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;

    // behavioural reference state
    logic [47:0] m_cnt, m_cmp;
    logic        m_flag, m_ien, m_held;

    always #10 clk = ~clk;

    etime_alarm uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        logic wr;
        logic eqv;
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_flag = 0; m_ien = 0; m_held = 1;
        end else begin
            wr  = bus_sel && bus_wr;
            eqv = (m_cnt == m_cmp);
            if (wr && bus_addr == 5'h1E && bus_wdata[0]) m_flag = 0;
            if (!m_held && eqv) m_flag = 1;
            m_held = eqv;
            if (wr && bus_addr == 5'h1C) m_ien = bus_wdata[0];
            if (wr && bus_addr == 5'h08) m_cmp[15:0]  = bus_wdata;
            if (wr && bus_addr == 5'h0A) m_cmp[31:16] = bus_wdata;
            if (wr && bus_addr == 5'h0C) m_cmp[47:32] = bus_wdata;
            if (wr && bus_addr == 5'h00)      m_cnt[15:0]  = bus_wdata;
            else if (wr && bus_addr == 5'h02) m_cnt[31:16] = bus_wdata;
            else if (wr && bus_addr == 5'h04) m_cnt[47:32] = bus_wdata;
            else if (tick) m_cnt = m_cnt + 48'd1;
        end
    end

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00: return m_cnt[15:0];
            5'h02: return m_cnt[31:16];
            5'h04: return m_cnt[47:32];
            5'h08: return m_cmp[15:0];
            5'h0A: return m_cmp[31:16];
            5'h0C: return m_cmp[47:32];
            5'h1C: return {15'd0, m_ien};
            5'h1E: return {15'd0, m_flag};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8: irq compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n) check("R8 irq per cycle", {47'd0, irq}, {47'd0, m_flag & m_ien});
    end

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d, input logic t);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick = t;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; tick = 0;
    endtask

    task automatic rd(input logic [4:0] a, input string tag, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2;
        v = bus_rdata;
        check(tag, {32'd0, v}, {32'd0, exp_read(a)});
        bus_sel = 0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
        end
        @(negedge clk); tick = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, lo, mi, hi;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        for (int a = 0; a < 32; a += 2) begin
            rd(5'(a), "R10 reset read", v);
            check("R10 reset zero", {32'd0, v}, 48'd0);
        end
        // R1 counting
        run_ticks(5);
        rd(5'h00, "R1 count", v);
        check("R1 five ticks", {32'd0, v}, 48'd5);
        idle(3);
        rd(5'h00, "R1 hold", v);
        check("R1 hold no tick", {32'd0, v}, 48'd5);
        // R2/R3 load 3 seconds
        bus_write(5'h00, 16'h8000, 0);
        bus_write(5'h02, 16'h0001, 0);
        bus_write(5'h04, 16'h0000, 0);
        rd(5'h00, "R2 low", lo);
        rd(5'h02, "R2 mid", mi);
        rd(5'h04, "R2 high", hi);
        check("R2 seconds", ({32'd0, hi} << 17) | ({32'd0, mi} << 1) | {32'd0, lo >> 15}, 48'd3);
        // R4/R5/R8 alarm four ticks ahead
        bus_write(5'h1C, 16'h0001, 0);
        bus_write(5'h08, 16'h8004, 0);
        bus_write(5'h0A, 16'h0001, 0);
        bus_write(5'h0C, 16'h0000, 0);
        rd(5'h08, "R4 cmp low", v);
        check("R4 cmp low value", {32'd0, v}, 48'h8004);
        rd(5'h0A, "R4 cmp mid", v);
        rd(5'h1E, "R5 before match", v);
        check("R5 flag clear before", {32'd0, v}, 48'd0);
        run_ticks(4);
        idle(1);
        rd(5'h1E, "R5 after match", v);
        check("R5 flag set", {32'd0, v}, 48'd1);
        check("R8 irq high", {47'd0, irq}, 48'd1);
        // R7 write-0 no effect, write-1 clears; R5 upper bits zero
        bus_write(5'h1E, 16'hFFFE, 0);
        rd(5'h1E, "R7 write zero", v);
        check("R7 flag kept", {32'd0, v}, 48'd1);
        bus_write(5'h1E, 16'h0001, 0);
        rd(5'h1E, "R7 cleared", v);
        check("R7 flag cleared", {32'd0, v}, 48'd0);
        run_ticks(3);
        rd(5'h1E, "R6 past match", v);
        check("R6 no reset after pass", {32'd0, v}, 48'd0);
        // R6 held equality: count now 0x18007
        bus_write(5'h08, 16'h8007, 0);
        idle(2);
        rd(5'h1E, "R6 equal set", v);
        check("R6 flag on equal", {32'd0, v}, 48'd1);
        bus_write(5'h1E, 16'h0001, 0);
        idle(6);
        rd(5'h1E, "R6 equal held", v);
        check("R6 no refire", {32'd0, v}, 48'd0);
        // R7 set beats clear on same edge
        bus_write(5'h08, 16'h8009, 0);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        bus_sel = 1; bus_wr = 1; bus_addr = 5'h1E; bus_wdata = 16'h0001;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        rd(5'h1E, "R7 priority", v);
        check("R7 set wins", {32'd0, v}, 48'd1);
        // R3 write with tick in same cycle
        bus_write(5'h00, 16'h1234, 1);
        rd(5'h00, "R3 write tick", v);
        check("R3 tick dropped", {32'd0, v}, 48'h1234);
        rd(5'h02, "R3 mid kept", v);
        check("R3 neighbour", {32'd0, v}, 48'd1);
        // R9 wrap
        bus_write(5'h04, 16'hFFFF, 0);
        bus_write(5'h02, 16'hFFFF, 0);
        bus_write(5'h00, 16'hFFFF, 0);
        run_ticks(1);
        rd(5'h00, "R9 low", v);  check("R9 low zero", {32'd0, v}, 48'd0);
        rd(5'h02, "R9 mid", v);  check("R9 mid zero", {32'd0, v}, 48'd0);
        rd(5'h04, "R9 high", v); check("R9 high zero", {32'd0, v}, 48'd0);
        // R11 unmapped
        bus_write(5'h06, 16'hABCD, 0);
        bus_write(5'h10, 16'h5555, 0);
        rd(5'h06, "R11 read 06", v); check("R11 zero 06", {32'd0, v}, 48'd0);
        rd(5'h10, "R11 read 10", v); check("R11 zero 10", {32'd0, v}, 48'd0);
        rd(5'h04, "R11 cnt kept", v);
        rd(5'h0C, "R11 cmp kept", v);
        // R8 irq masked
        bus_write(5'h1E, 16'h0001, 0);
        bus_write(5'h1C, 16'h0000, 0);
        bus_write(5'h0C, 16'h0000, 0);
        bus_write(5'h0A, 16'h0000, 0);
        bus_write(5'h08, 16'h0003, 0);
        run_ticks(3);
        idle(1);
        rd(5'h1E, "R8 masked flag", v);
        check("R8 flag set masked", {32'd0, v}, 48'd1);
        check("R8 irq low masked", {47'd0, irq}, 48'd0);
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule